// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block models an eight-stage parallel-in, serial-out shift register. It runs entirely on a fast system clock. Every external pin is sampled by a two-flop synchronizer. The pins are the parallel word, a serial input, an active-low load select, a shift clock and a clock-inhibit. A shift is triggered by a rising edge of the combined gate term (shift clock OR inhibit), as seen in the synchronized samples. Either pin held high therefore blocks the other. Raising the inhibit while the shift clock is low counts as a shift edge.

While the load select is low, every stage copies its parallel input on each system cycle, whatever the clock, inhibit and serial pins do. While it is high, the register holds its contents or shifts by one place per detected edge. Data moves from stage A (`par_in[0]`) toward stage H (`par_in[WIDTH-1]`), and the serial input enters stage A. The last stage drives a true output and a complement output. A host that reads the serial output therefore sees the loaded word from H down to A, followed by the serial bits in the order they were presented.

Top module: `pload_shreg`

## Requirements
- R1: A pin change made between two system clock edges reaches the stages on the third following rising edge: two synchronizer flops, then the stage register.
- R2: While the synchronized load select is 0, every stage i copies `par_in[i]` on each system cycle. Stage A is `par_in[0]`, stage H is `par_in[WIDTH-1]`, and `q_out` follows `par_in[WIDTH-1]` (after R1 latency) as that pin changes.
- R3: On a shift edge with the load select at 1, stage i+1 takes the old stage i and stage A takes `ser_in`. Successive shifts present the loaded word on `q_out` in H-to-A order, then the serial bits in the order they were applied.
- R4: A shift edge is a 0-to-1 change of (`sclk` OR `sinh`) between two consecutive synchronized samples. There is at most one shift per such change.
- R5: While `sinh` is held at 1, toggling `sclk` causes no shift.
- R6: A rise of `sinh` while `sclk` is 0 causes exactly one shift. Its fall causes none.
- R7: With the load select at 1 and no shift edge, all stages keep their values.
- R8: If the load select is 0 in the same sample as a shift edge, the load wins and no shift occurs.
- R9: A synchronous active-high `rst` clears all stages, so `q_out`=0 and `q_out_n`=1. Releasing reset with `sclk` or `sinh` already high produces no shift and no load.
- R10: `q_out_n` is always the complement of `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | WIDTH | Parallel data; bit 0 is stage A, bit WIDTH-1 is stage H |
| ser_in | input | 1 | Serial data entering stage A on a shift |
| shld_n | input | 1 | 0 = load parallel data (level), 1 = shift/hold |
| sclk | input | 1 | External shift clock |
| sinh | input | 1 | Clock inhibit, ORed with the shift clock |
| q_out | output | 1 | Last stage (H) |
| q_out_n | output | 1 | Complement of the last stage |

## Verification
The assertions assume that every pin is steady for at least one system cycle, so that each synchronized sample is a clean level. They also assume that a load-select pulse and a gate-term rise meant to coincide change at the same instant and therefore travel through the synchronizer together. The bench changes pins only on falling system clock edges. It holds each level for several cycles, except in the one-cycle load pulse of the priority test, where the load select and the clock change in the same cycle. It also drives the inhibit rise while the clock is low on purpose, to exercise the extra-shift case.

// File: rtl/pload_pkg.sv
package pload_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } stage_mode_e;

  // Combined gate term: either pin high masks the other.
  function automatic logic gate_term(input logic clk_pin, input logic inh_pin);
    return clk_pin | inh_pin;
  endfunction

  // Load (active-low select) has priority over a detected shift edge.
  function automatic stage_mode_e pick_mode(input logic shld_n_s, input logic edge_s);
    if (!shld_n_s)   return MODE_LOAD;
    else if (edge_s) return MODE_SHIFT;
    else             return MODE_HOLD;
  endfunction

endpackage

// File: rtl/pload_sync.sv
module pload_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)        chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_in;
        else            chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pload_edge.sv
module pload_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic inh_s,
  output logic gate_s,
  output logic shift_ev
);
  import pload_pkg::*;

  logic gate_q;

  assign gate_s = gate_term(clk_s, inh_s);

  // Reset to 1: a gate term already high at reset release is not an edge.
  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b1;
    else     gate_q <= gate_s;
  end

  assign shift_ev = gate_s & ~gate_q;
endmodule

// File: rtl/pload_stages.sv
module pload_stages #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pload_pkg::stage_mode_e   mode,
  input  logic [WIDTH-1:0]         par_s,
  input  logic                     ser_s,
  output logic [WIDTH-1:0]         stage_q
);
  import pload_pkg::*;

  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] cur,
                                                input logic fill);
    return {cur[WIDTH-2:0], fill};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      case (mode)
        MODE_LOAD:  stage_q <= par_s;
        MODE_SHIFT: stage_q <= shift_up(stage_q, ser_s);
        default:    stage_q <= stage_q;
      endcase
    end
  end
endmodule

// File: rtl/pload_shreg.sv
module pload_shreg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             shld_n,
  input  logic             sclk,
  input  logic             sinh,
  output logic             q_out,
  output logic             q_out_n
);
  import pload_pkg::*;

  localparam int PIN_W = WIDTH + 4;
  // Packing: {shld_n, sclk, sinh, ser_in, par_in}; load select and clock reset high.
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b1, 1'b0, 1'b0, {WIDTH{1'b0}}};

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic [WIDTH-1:0] par_s;
  logic             ser_s, shld_s, clk_s, inh_s;
  logic             gate_s, shift_ev, load_ev;
  stage_mode_e      mode;
  logic [WIDTH-1:0] stage_q;

  assign pins_raw = {shld_n, sclk, sinh, ser_in, par_in};

  pload_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pins_raw),
    .d_out (pins_s)
  );

  assign par_s  = pins_s[WIDTH-1:0];
  assign ser_s  = pins_s[WIDTH];
  assign inh_s  = pins_s[WIDTH+1];
  assign clk_s  = pins_s[WIDTH+2];
  assign shld_s = pins_s[WIDTH+3];

  pload_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .clk_s    (clk_s),
    .inh_s    (inh_s),
    .gate_s   (gate_s),
    .shift_ev (shift_ev)
  );

  assign mode    = pick_mode(shld_s, shift_ev);
  assign load_ev = (mode == MODE_LOAD);

  pload_stages #(.WIDTH(WIDTH)) u_stages (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .par_s   (par_s),
    .ser_s   (ser_s),
    .stage_q (stage_q)
  );

  assign q_out   = stage_q[WIDTH-1];
  assign q_out_n = ~stage_q[WIDTH-1];
endmodule

// File: rtl/pload_shreg_chk.sv
module pload_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] stage_q,
  input logic [WIDTH-1:0] par_s,
  input logic             ser_s,
  input logic             shld_s,
  input logic             clk_s,
  input logic             inh_s,
  input logic             gate_s,
  input logic             shift_ev,
  input logic             q_out,
  input logic             q_out_n
);
  // R3: a shift with no load moves every stage up one and fills A from serial
  a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && shld_s) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_s)});

  // R2: load copies the parallel word
  a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
    !shld_s |=> stage_q == $past(par_s));

  // R7: no edge and no load means hold
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (shld_s && !shift_ev) |=> $stable(stage_q));

  // R4: an edge needs the gate term to be high now and low in the previous sample
  a_r4_edge_source: assert property (@(posedge clk) disable iff (rst)
    shift_ev |-> (clk_s || inh_s) && !$past(gate_s));

  // R5: inhibit held high across two samples blocks any edge
  a_r5_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
    (inh_s && $past(inh_s)) |-> !shift_ev);

  // R8: a load in the same sample as an edge leaves no shifted value
  a_r8_load_priority: assert property (@(posedge clk) disable iff (rst)
    (!shld_s && shift_ev) |=> stage_q == $past(par_s));

  // R9: reset clears the stages
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (stage_q == '0));

  // R10: complementary outputs
  a_r10_complement: assert property (@(posedge clk) disable iff (rst)
    q_out_n == ~q_out);
endmodule

bind pload_shreg pload_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stage_q  (stage_q),
  .par_s    (par_s),
  .ser_s    (ser_s),
  .shld_s   (shld_s),
  .clk_s    (clk_s),
  .inh_s    (inh_s),
  .gate_s   (gate_s),
  .shift_ev (shift_ev),
  .q_out    (q_out),
  .q_out_n  (q_out_n)
);

// File: tb/tb_pload_shreg.sv
`timescale 1ns/1ps
module tb_pload_shreg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic         shld_n = 1'b1;
  logic         sclk = 1'b1;
  logic         sinh = 1'b0;
  logic         q_out, q_out_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pload_shreg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
    .shld_n(shld_n), .sclk(sclk), .sinh(sinh),
    .q_out(q_out), .q_out_n(q_out_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
    n_checks++;
    if (q_out_n !== ~act && act === q_out) begin
      n_fail++;
      $display("FAIL R10: q_out_n %b expected %b", q_out_n, ~q_out);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] v);
    par_in = v; shld_n = 1'b0; settle();
    shld_n = 1'b1; settle();
  endtask

  // one shift clock pulse with inhibit low
  task automatic pulse_clk();
    sclk = 1'b0; settle();
    sclk = 1'b1; settle();
  endtask

  task automatic t_reset();
    // sclk high through reset: release must not shift
    par_in = '1; repeat (4) @(negedge clk);
    rst = 1'b0; settle();
    check("R9 reset q_out", q_out, 1'b0);
    check("R9 reset q_out_n", q_out_n, 1'b1);
  endtask

  task automatic t_latency();
    par_in = 8'h80;
    @(negedge clk) shld_n = 1'b0;
    @(negedge clk); check("R1 after 1 edge", q_out, 1'b0);
    @(negedge clk); check("R1 after 2 edges", q_out, 1'b0);
    @(negedge clk); check("R1 after 3 edges", q_out, 1'b1);
    shld_n = 1'b1; settle();
  endtask

  task automatic t_transparent();
    par_in = 8'h00; shld_n = 1'b0; settle();
    check("R2 load follows H=0", q_out, 1'b0);
    par_in = 8'h80; settle();
    check("R2 load follows H=1", q_out, 1'b1);
    // clock pulses ignored during load
    sclk = 1'b0; settle(); sclk = 1'b1; settle();
    check("R2 clock ignored in load", q_out, 1'b1);
    shld_n = 1'b1; settle();
  endtask

  task automatic t_shift_out();
    logic [W-1:0] word = 8'hA5;
    logic [W-1:0] sbits = 8'b1100_1010;
    load_word(word);
    for (int i = 0; i < W; i++) begin
      check($sformatf("R3 loaded bit %0d", W-1-i), q_out, word[W-1-i]);
      ser_in = sbits[i];
      pulse_clk();
    end
    for (int i = 0; i < W; i++) begin
      check($sformatf("R3 serial bit %0d", i), q_out, sbits[i]);
      ser_in = 1'b0;
      pulse_clk();
    end
  endtask

  task automatic t_hold();
    load_word(8'h80);
    repeat (20) @(negedge clk);
    check("R7 hold without edge", q_out, 1'b1);
  endtask

  task automatic t_inhibit_blocks();
    load_word(8'h80);         // sclk is high here
    sinh = 1'b1; settle();
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b0; settle(); sclk = 1'b1; settle();
    end
    check("R5 inhibit blocks clock", q_out, 1'b1);
    sinh = 1'b0; settle();
    check("R4 inhibit fall with clock high", q_out, 1'b1);
  endtask

  task automatic t_inhibit_rise_low();
    load_word(8'h40);         // G=1, H=0
    sclk = 1'b0; settle();
    check("R4 clock fall no shift", q_out, 1'b0);
    sinh = 1'b1; settle();
    check("R6 inhibit rise shifts once", q_out, 1'b1);
    sinh = 1'b0; settle();
    check("R6 inhibit fall no shift", q_out, 1'b1);
    sinh = 1'b1; settle();
    check("R6 second rise shifts", q_out, 1'b0);
    sinh = 1'b0; sclk = 1'b1; settle();
  endtask

  task automatic t_load_priority();
    load_word(8'h00);
    sclk = 1'b0; settle();
    par_in = 8'h80;
    @(negedge clk); shld_n = 1'b0; sclk = 1'b1;
    @(negedge clk); shld_n = 1'b1;
    settle();
    check("R8 load beats same-sample edge", q_out, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_transparent();
    t_shift_out();
    t_hold();
    t_inhibit_blocks();
    t_inhibit_rise_low();
    t_load_priority();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule